// File: doc/BRIEF.md
# Self-Refreshing Triple-Redundant Register

This block holds a data word. Each bit of the word is kept in three separate flip-flops. A majority voter reads the three copies and drives the visible output. The voter also sits inside the feedback loop. While no load is requested, the voted word is written back into all three copies on every clock. A copy that has been disturbed is therefore repaired at the next edge, and a held value survives for any length of time instead of collecting errors.

When the load input is high, the new word goes into all three copies at once. Each bit reports whether its copies disagree, and a single flag combines those per-bit reports. For verification, a fault-injection mask can invert any chosen copy of any chosen bit at the next clock edge. This lets a bench create an upset and watch it being corrected.

Top module: `tmr_reg_top`

## Requirements
- R1: When `rst` is high at a clock edge, all copies of all bits become 0. After that edge `dataOut` is 0 and `errFlag` is 0.
- R2: When `loadEn` is high and `rst` is low at an edge, with no injection, `dataIn` is written into all three copies. After the edge `dataOut` equals that word and `mismatch` is 0.
- R3: While `loadEn` is low and no injection occurs, `dataOut` keeps its value from cycle to cycle, for as long as the load stays low.
- R4: Injection mask bit `c*WIDTH+i` (copy c = 0, 1 or 2; bit i) inverts copy c of bit i as that copy is written at the edge. When exactly one mask bit is set and all copies agree, `dataOut` after the edge is the same as it would be with no injection.
- R5: After a one-hot injection into a state with no disagreement, `mismatch` has exactly bit i set during the following cycle.
- R6: Any edge with `loadEn` low, `rst` low and no injection writes the voted value into all copies. After it, `mismatch` is 0 whatever the copies held before.
- R7: `errFlag` is high exactly when at least one bit of `mismatch` is high.
- R8: An injection coinciding with a load inverts the chosen copy of the new word. `dataOut` still shows the loaded word, and the chosen bit is flagged.
- R9: Reset takes priority over load and over injection.
- R10: The voter picks copies 0 and 1 when they agree and copy 2 when they differ. So if two copies of one bit are inverted at the same edge, that output bit inverts. The next refresh then makes all three copies agree on the inverted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Load the input word into all copies |
| dataIn | input | WIDTH | Word to load |
| injMask | input | 3*WIDTH | Fault-injection mask, bit c*WIDTH+i flips copy c of bit i |
| dataOut | output | WIDTH | Majority-voted word |
| mismatch | output | WIDTH | Per-bit copy disagreement |
| errFlag | output | 1 | OR of all mismatch bits |

## Verification
The block is driven with long holds after a load, single-copy upsets aimed at each of the three copies in turn, upsets that coincide with a load, double upsets on one bit, and reset asserted together with load and injection. An upset on copy 2 exercises the path where the voter passes copies 0 and 1 straight through. Upsets on copies 0 or 1 exercise the path where copy 2 is selected. Double upsets show that the output follows the majority rather than any fixed copy. A random mix of loads, holds and injections is checked every cycle against a bench model of the three copies, which separates a refresh that really repairs from a hold that merely keeps the output stable.

// File: rtl/tmr_reg_pkg.sv
package tmr_reg_pkg;
  localparam int COPIES = 3;

  typedef struct packed {
    logic clear;
    logic load;
    logic inject;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_reg_ctrl.sv
module tmr_reg_ctrl
  import tmr_reg_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int MASKW = COPIES * WIDTH
) (
  input  logic             rst,
  input  logic             loadEn,
  input  logic [MASKW-1:0] injMask,
  output tmrStrobe_t       strobe,
  output logic [MASKW-1:0] injGated
);
  // Reset outranks everything (R9); injection is masked while clearing.
  always_comb begin
    strobe.clear  = rst;
    strobe.load   = loadEn & ~rst;
    strobe.inject = ~rst & (|injMask);
    injGated      = strobe.inject ? injMask : '0;
  end
endmodule

// File: rtl/tmr_reg_voter.sv
module tmr_reg_voter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] copyA,
  input  logic [WIDTH-1:0] copyB,
  input  logic [WIDTH-1:0] copyC,
  output logic [WIDTH-1:0] voted,
  output logic [WIDTH-1:0] disagree
);
  // Per bit: copies A and B act as selects; C is passed only when they differ.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      case ({copyA[i], copyB[i]})
        2'b00:   voted[i] = 1'b0;
        2'b11:   voted[i] = 1'b1;
        default: voted[i] = copyC[i];
      endcase
      disagree[i] = (copyA[i] ^ copyB[i]) | (copyA[i] ^ copyC[i]);
    end
  end
endmodule

// File: rtl/tmr_reg_datapath.sv
module tmr_reg_datapath
  import tmr_reg_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int MASKW = COPIES * WIDTH
) (
  input  logic             clk,
  input  tmrStrobe_t       strobe,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [MASKW-1:0] injMask,
  output logic [WIDTH-1:0] dataOut,
  output logic [WIDTH-1:0] mismatch,
  output logic             errFlag
);
  logic [COPIES-1:0][WIDTH-1:0] copyQ;
  logic [WIDTH-1:0]             votedVal;

  // One storage lane per copy; each lane picks its own next value.
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    logic [WIDTH-1:0] laneQ;
    logic [WIDTH-1:0] laneNext;
    logic [WIDTH-1:0] laneFlip;

    always_comb begin
      laneFlip = strobe.inject ? injMask[c*WIDTH +: WIDTH] : '0;
      laneNext = (strobe.load ? dataIn : votedVal) ^ laneFlip;
    end

    always_ff @(posedge clk) begin
      if (strobe.clear) laneQ <= '0;
      else              laneQ <= laneNext;
    end

    assign copyQ[c] = laneQ;
  end

  tmr_reg_voter #(.WIDTH(WIDTH)) u_voter (
    .copyA   (copyQ[0]),
    .copyB   (copyQ[1]),
    .copyC   (copyQ[2]),
    .voted   (votedVal),
    .disagree(mismatch)
  );

  assign dataOut = votedVal;
  assign errFlag = |mismatch;
endmodule

// File: rtl/tmr_reg_top.sv
module tmr_reg_top
  import tmr_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    loadEn,
  input  logic [WIDTH-1:0]        dataIn,
  input  logic [3*WIDTH-1:0]      injMask,
  output logic [WIDTH-1:0]        dataOut,
  output logic [WIDTH-1:0]        mismatch,
  output logic                    errFlag
);
  tmrStrobe_t               strobe;
  logic [COPIES*WIDTH-1:0]  injGated;

  tmr_reg_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .rst     (rst),
    .loadEn  (loadEn),
    .injMask (injMask),
    .strobe  (strobe),
    .injGated(injGated)
  );

  tmr_reg_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .injMask (injGated),
    .dataOut (dataOut),
    .mismatch(mismatch),
    .errFlag (errFlag)
  );
endmodule

// File: rtl/tmr_reg_checker.sv
module tmr_reg_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               loadEn,
  input logic [WIDTH-1:0]   dataIn,
  input logic [3*WIDTH-1:0] injMask,
  input logic [WIDTH-1:0]   dataOut,
  input logic [WIDTH-1:0]   mismatch,
  input logic               errFlag
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (dataOut == '0 && !errFlag));

  assert_load_all_R2: assert property (@(posedge clk) disable iff (rst)
    (loadEn && injMask == '0) |=> (dataOut == $past(dataIn) && mismatch == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && injMask == '0 && !errFlag) |=> $stable(dataOut));

  assert_single_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !errFlag && $countones(injMask) == 1) |=> $stable(dataOut));

  assert_single_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (!errFlag && $countones(injMask) == 1) |=> ($countones(mismatch) == 1 && errFlag));

  assert_refresh_R6: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && injMask == '0) |=> (mismatch == '0 && !errFlag));
endmodule

bind tmr_reg_top tmr_reg_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_tmr_reg_top.sv
module test_tmr_reg_top;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           loadEn = 1'b0;
  logic [W-1:0]   dataIn = '0;
  logic [3*W-1:0] injMask = '0;
  logic [W-1:0]   dataOut, mismatch;
  logic           errFlag;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  logic [W-1:0] mA = '0, mB = '0, mC = '0;

  always #4 clk = ~clk;

  tmr_reg_top #(.WIDTH(W)) i_tmr_reg_top (.*);

  function automatic logic [W-1:0] majority(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [W-1:0] differ(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    return (a ^ b) | (b ^ c);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply inputs, take one edge, update the model, compare all outputs.
  task automatic cycle(string tag, logic r, logic ld, logic [W-1:0] d, logic [3*W-1:0] inj);
    logic [W-1:0] v;
    rst = r; loadEn = ld; dataIn = d; injMask = inj;
    @(posedge clk);
    v = majority(mA, mB, mC);
    if (r) begin
      mA = '0; mB = '0; mC = '0;
    end else begin
      mA = (ld ? d : v) ^ inj[0 +: W];
      mB = (ld ? d : v) ^ inj[W +: W];
      mC = (ld ? d : v) ^ inj[2*W +: W];
    end
    #2;
    chk({tag, " dataOut"}, 32'(dataOut), 32'(majority(mA, mB, mC)));
    chk({tag, " mismatch"}, 32'(mismatch), 32'(differ(mA, mB, mC)));
    chk({tag, " errFlag R7"}, 32'(errFlag), 32'(|differ(mA, mB, mC)));
    @(negedge clk);
  endtask

  function automatic logic [3*W-1:0] hit(int copy, int b);
    logic [3*W-1:0] m = '0;
    m[copy*W + b] = 1'b1;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2741));
    @(negedge clk);
    cycle("R1 reset", 1'b1, 1'b0, '0, '0);
    chk("R1 reset zero", 32'(dataOut), 32'h0);

    cycle("R2 load", 1'b0, 1'b1, 8'hA5, '0);
    chk("R2 loaded word", 32'(dataOut), 32'hA5);
    for (int k = 0; k < 20; k++) cycle("R3 hold", 1'b0, 1'b0, 8'h3C, '0);
    chk("R3 held word", 32'(dataOut), 32'hA5);

    cycle("R4 R5 upset copy0 bit3", 1'b0, 1'b0, '0, hit(0, 3));
    chk("R4 output kept", 32'(dataOut), 32'hA5);
    chk("R5 flagged bit", 32'(mismatch), 32'h08);
    cycle("R6 refresh", 1'b0, 1'b0, '0, '0);
    chk("R6 repaired", 32'(errFlag), 32'h0);

    cycle("R4 R5 upset copy2 bit7", 1'b0, 1'b0, '0, hit(2, 7));
    chk("R5 flagged bit7", 32'(mismatch), 32'h80);
    cycle("R6 refresh", 1'b0, 1'b0, '0, '0);
    cycle("R4 R5 upset copy1 bit0", 1'b0, 1'b0, '0, hit(1, 0));
    chk("R4 output kept copy1", 32'(dataOut), 32'hA5);
    cycle("R6 refresh", 1'b0, 1'b0, '0, '0);

    cycle("R8 upset during load", 1'b0, 1'b1, 8'h5A, hit(1, 4));
    chk("R8 loaded word", 32'(dataOut), 32'h5A);
    chk("R8 flagged bit4", 32'(mismatch), 32'h10);
    cycle("R6 refresh", 1'b0, 1'b0, '0, '0);

    cycle("R10 double upset", 1'b0, 1'b0, '0, hit(0, 2) | hit(1, 2));
    chk("R10 inverted bit", 32'(dataOut), 32'h5E);
    cycle("R10 refresh", 1'b0, 1'b0, '0, '0);
    chk("R10 agreed", 32'(mismatch), 32'h0);
    chk("R10 kept inverted", 32'(dataOut), 32'h5E);
    cycle("R10 double upset A C", 1'b0, 1'b0, '0, hit(0, 6) | hit(2, 6));
    chk("R10 inverted bit6", 32'(dataOut), 32'h1E);

    cycle("R9 reset priority", 1'b1, 1'b1, 8'hFF, hit(2, 1));
    chk("R9 cleared", 32'(dataOut), 32'h0);
    chk("R9 no flag", 32'(errFlag), 32'h0);

    for (int k = 0; k < 3000; k++) begin
      int p = int'($urandom_range(99));
      int q = int'($urandom_range(99));
      logic [3*W-1:0] inj = '0;
      int b = int'($urandom_range(W-1));
      if (q < 25) inj = hit(int'($urandom_range(2)), b);
      else if (q < 30) inj = hit(0, b) | hit(int'($urandom_range(1, 2)), b);
      cycle("R2 R3 R6 random", p < 1, p < 30, W'($urandom), inj);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule